// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer

This block holds a 16-bit up-counter shared by four timer channels and a small register file on a simple synchronous bus. Each channel is set up either to timestamp a rising edge on its input or to act on its output pin when the counter reaches the channel's value. Each channel has a flag and an interrupt enable. The counter has an overflow flag of its own.

Channel 3 has extra reach. When it fires, it can impose levels on the pins of any channels chosen by an override mask and data pair. That level wins over those channels' own compares in the same cycle. Channel 3 can also restart the counter from zero. Software can fire any compare action at once through a force register; a forced action leaves the flags alone. Each pin is driven either by the compare logic or by a port latch. Writes to the latch stay hidden while the compare logic owns the pin.

The counter is built around a two-state machine. In HALT the counter holds its value. HALT goes to RUN when the run bit is set. RUN goes back to HALT when the run bit is cleared. In RUN the counter increments each clock or clears on a channel-3 restart.

Each capture input passes through a two-stage synchroniser and then a two-state edge machine. LOW goes to HIGH when the synchronised input is 1; that transition is the capture event. HIGH goes back to LOW when the synchronised input returns to 0.

Top module: `tmr_capcmp4`

## Requirements
- R1: After reset, every register reads 0, the counter is halted at 0, and pin_out, irq_ch and irq_ovf are all 0.
- R2: While bit 0 of CTRL (address 1) is 1, the counter increases by one each clock, and its value reads at address 0. While that bit is 0, the counter holds its value.
- R3: A channel whose bit in DIR (address 2) is 0 is a capture channel. One rising edge on cap_in[n] loads the channel register (address 12+n) once. The value loaded is v+2, where v is the count in the clock before the edge was sampled. The same edge sets FLAG bit n. Falling edges and a held-high input do nothing.
- R4: A channel whose DIR bit is 1 is a compare channel. When the running counter equals its register, FLAG bit n is set and the pin action applies. The action is selected by MODE (address 3) bits [2n+1:2n]: 01 toggles the pin, 10 drives it low, 11 drives it high.
- R5: The compare logic owns pin n when DIR bit n is 1 and either its MODE field is nonzero or OVMASK bit n is 1. Otherwise pin_out[n] shows PORT bit n. With a MODE field of 00, a match still sets the flag.
- R6: Writing 1 to bit n of FORCE (address 6) on a compare channel applies that channel's action at the write's clock edge and does not set its flag. FORCE always reads 0.
- R7: When channel 3 compares (by match or by force), every channel n with OVMASK (address 7) bit n set takes OVDATA (address 8) bit n as its compare level. This overrides that channel's own compare in the same cycle.
- R8: With CTRL bit 1 set, a channel-3 match (not a force) makes the counter 0 on the next clock, whatever channel 3's MODE field is.
- R9: Writes to PORT (address 9) are always stored and read back. They do not change a pin owned by the compare logic, and they appear on the pin once ownership ends.
- R10: irq_ch[n] equals FLAG bit n AND IEN (address 4) bit n. irq_ovf equals FLAG bit 4 AND IEN bit 4.
- R11: Writing FLAG (address 5) clears the bits written as 1 and leaves the bits written as 0 untouched. A flag being set in the same cycle stays set.
- R12: The counter rolling over from 0xFFFF to 0x0000 by increment sets FLAG bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| cap_in | input | 4 | Capture inputs, one per channel |
| pin_out | output | 4 | Channel pin levels |
| irq_ch | output | 4 | Per-channel interrupt requests, active high |
| irq_ovf | output | 1 | Overflow interrupt request, active high |

## Verification
Channel 0 and channel 3 compare in the same clock in one scenario, and they disagree on channel 0's pin. Both channel registers are loaded with the same future count. Channel 0 is set to drive high, and the override mask and data tell channel 3 to drive channel 0 low. The pin must settle low and both flags must be set. A second overlap is a rising capture input held high while its flag is being cleared. That flag must stay clear and must not be set a second time.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [3:0] A_COUNT   = 4'd0;
    localparam logic [3:0] A_CTRL    = 4'd1;
    localparam logic [3:0] A_DIR     = 4'd2;
    localparam logic [3:0] A_MODE    = 4'd3;
    localparam logic [3:0] A_IEN     = 4'd4;
    localparam logic [3:0] A_FLAG    = 4'd5;
    localparam logic [3:0] A_FORCE   = 4'd6;
    localparam logic [3:0] A_OVMASK  = 4'd7;
    localparam logic [3:0] A_OVDATA  = 4'd8;
    localparam logic [3:0] A_PORT    = 4'd9;
    localparam int         A_CH_BASE = 12;

    typedef enum logic {
        CNT_HALT = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

    typedef enum logic {
        EDG_LOW  = 1'b0,
        EDG_HIGH = 1'b1
    } edge_state_e;

    typedef enum logic [1:0] {
        OC_NONE   = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_LOW    = 2'b10,
        OC_HIGH   = 2'b11
    } oc_act_e;

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             counting,
    output logic             wrap
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_HALT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALT: if (run_en)  state_d = CNT_RUN;
            CNT_RUN:  if (!run_en) state_d = CNT_HALT;
        endcase
    end

    // outputs
    always_comb begin
        counting = (state_q == CNT_RUN);
        wrap     = counting && !clr && (cnt == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (counting) cnt <= clr ? '0 : cnt + 1'b1;
    end

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !clr) |=> (cnt == $past(cnt) + 1'b1));

    a_r8_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && clr) |=> (cnt == '0));

    a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !counting |=> $stable(cnt));

endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    import tmr_pkg::*;

    logic [SYNC_DEPTH-1:0] sync_q;
    logic                  s;
    edge_state_e           state_q, state_d;

    generate
        if (SYNC_DEPTH == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_DEPTH-2:0], din};
            end
        end
    endgenerate

    assign s = sync_q[SYNC_DEPTH-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDG_LOW;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDG_LOW:  if (s)  state_d = EDG_HIGH;
            EDG_HIGH: if (!s) state_d = EDG_LOW;
        endcase
    end

    // outputs
    always_comb begin
        rise = (state_q == EDG_LOW) && s;
    end

    a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tmr_oc_pin.sv
module tmr_oc_pin (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act,
    input  logic [1:0] ml,
    input  logic       ovr,
    input  logic       ovr_val,
    input  logic       owned,
    input  logic       port_bit,
    output logic       pin
);
    import tmr_pkg::*;

    logic oc_q, oc_d;

    always_comb begin
        oc_d = oc_q;
        if (ovr) begin
            oc_d = ovr_val;
        end else if (act) begin
            unique case (oc_act_e'(ml))
                OC_NONE:   oc_d = oc_q;
                OC_TOGGLE: oc_d = ~oc_q;
                OC_LOW:    oc_d = 1'b0;
                OC_HIGH:   oc_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oc_q <= 1'b0;
        else        oc_q <= oc_d;
    end

    assign pin = owned ? oc_q : port_bit;

    a_r7_override_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> (oc_q == $past(ovr_val)));

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !ovr) |=> $stable(oc_q));

endmodule

// File: rtl/tmr_capcmp4.sv
module tmr_capcmp4 #(
    parameter int CNT_W      = 16,
    parameter int NCH        = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [NCH-1:0]   cap_in,
    output logic [NCH-1:0]   pin_out,
    output logic [NCH-1:0]   irq_ch,
    output logic             irq_ovf
);
    import tmr_pkg::*;

    localparam int OVR = NCH - 1;
    localparam int MW  = 2 * NCH;

    // register file
    logic                       run_q, clr_en_q;
    logic [NCH-1:0]             dir_q, ovm_q, ovd_q, port_q;
    logic [MW-1:0]              mode_q;
    logic [NCH:0]               ien_q, flag_q;
    logic [NCH-1:0][CNT_W-1:0]  ch_q;

    // datapath
    logic [CNT_W-1:0] cnt;
    logic             counting, wrap, cnt_clr;
    logic [NCH-1:0]   rise, cap_ev, cmp_hit, frc, act, owned, wr_ch;
    logic [NCH:0]     flag_set, flag_clr;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_q),
        .clr      (cnt_clr),
        .cnt      (cnt),
        .counting (counting),
        .wrap     (wrap)
    );

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            tmr_edge_det #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (cap_in[n]),
                .rise  (rise[n])
            );

            assign wr_ch[n]   = bus_we && (bus_addr == 4'(A_CH_BASE + n));
            assign cap_ev[n]  = rise[n] && !dir_q[n];
            assign cmp_hit[n] = counting && dir_q[n] && (cnt == ch_q[n]);
            assign frc[n]     = bus_we && (bus_addr == A_FORCE) && bus_wdata[n] && dir_q[n];
            assign act[n]     = cmp_hit[n] || frc[n];
            assign owned[n]   = dir_q[n] && ((mode_q[2*n +: 2] != 2'b00) || ovm_q[n]);

            tmr_oc_pin u_pin (
                .clk      (clk),
                .rst_n    (rst_n),
                .act      (act[n]),
                .ml       (mode_q[2*n +: 2]),
                .ovr      (act[OVR] && ovm_q[n]),
                .ovr_val  (ovd_q[n]),
                .owned    (owned[n]),
                .port_bit (port_q[n]),
                .pin      (pin_out[n])
            );

            a_r6_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
                (frc[n] && !cmp_hit[n] && !flag_q[n]) |=> !flag_q[n]);

            a_r3_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
                cap_ev[n] |=> (ch_q[n] == $past(cnt)));
        end
    endgenerate

    assign cnt_clr  = cmp_hit[OVR] && clr_en_q;
    assign flag_set = {wrap, cmp_hit | cap_ev};
    assign flag_clr = (bus_we && bus_addr == A_FLAG) ? bus_wdata[NCH:0] : '0;

    // control and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            clr_en_q <= 1'b0;
            dir_q    <= '0;
            mode_q   <= '0;
            ien_q    <= '0;
            ovm_q    <= '0;
            ovd_q    <= '0;
            port_q   <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                A_CTRL:   {clr_en_q, run_q} <= bus_wdata[1:0];
                A_DIR:    dir_q  <= bus_wdata[NCH-1:0];
                A_MODE:   mode_q <= bus_wdata[MW-1:0];
                A_IEN:    ien_q  <= bus_wdata[NCH:0];
                A_OVMASK: ovm_q  <= bus_wdata[NCH-1:0];
                A_OVDATA: ovd_q  <= bus_wdata[NCH-1:0];
                A_PORT:   port_q <= bus_wdata[NCH-1:0];
                default:  ;
            endcase
        end
    end

    // flags: write-one-to-clear, set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | flag_set;
    end

    // channel registers: capture wins over a bus write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (cap_ev[n])     ch_q[n] <= cnt;
                else if (wr_ch[n]) ch_q[n] <= bus_wdata;
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_COUNT:  bus_rdata = cnt;
            A_CTRL:   bus_rdata = CNT_W'({clr_en_q, run_q});
            A_DIR:    bus_rdata = CNT_W'(dir_q);
            A_MODE:   bus_rdata = CNT_W'(mode_q);
            A_IEN:    bus_rdata = CNT_W'(ien_q);
            A_FLAG:   bus_rdata = CNT_W'(flag_q);
            A_OVMASK: bus_rdata = CNT_W'(ovm_q);
            A_OVDATA: bus_rdata = CNT_W'(ovd_q);
            A_PORT:   bus_rdata = CNT_W'(port_q);
            default: begin
                for (int n = 0; n < NCH; n++)
                    if (bus_addr == 4'(A_CH_BASE + n)) bus_rdata = ch_q[n];
            end
        endcase
    end

    assign irq_ch  = flag_q[NCH-1:0] & ien_q[NCH-1:0];
    assign irq_ovf = flag_q[NCH] & ien_q[NCH];

    a_r12_ovf_on_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[NCH]) |-> ($past(cnt) == '1));

    a_r8_restart_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !clr_en_q) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: tb/tmr_capcmp4_test.sv
module tmr_capcmp4_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  cap_in = '0;
    logic [3:0]  pin_out;
    logic [3:0]  irq_ch;
    logic        irq_ovf;

    int total = 0;
    int bad = 0;
    bit done = 0;

    tmr_capcmp4 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .pin_out   (pin_out),
        .irq_ch    (irq_ch),
        .irq_ovf   (irq_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(4'd0, v); check("R1 count", v, 0);
        rd(4'd1, v); check("R1 ctrl", v, 0);
        rd(4'd5, v); check("R1 flag", v, 0);
        check("R1 pins", pin_out, 0);
        check("R1 irq", {irq_ovf, irq_ch}, 0);
        idle(5);
        rd(4'd0, v); check("R2 halted", v, 0);
    endtask

    task automatic t_count;
        logic [15:0] v0, v1;
        wr(4'd1, 16'h0001);
        idle(3);
        rd(4'd0, v0);
        idle(10);
        rd(4'd0, v1);
        check("R2 step", 32'(v1 - v0), 10);
    endtask

    task automatic t_capture;
        logic [15:0] v, c;
        wr(4'd5, 16'h001F);
        rd(4'd0, v);
        cap_in[1] = 1'b1;
        idle(3);
        rd(4'd13, c); check("R3 captured value", c, 32'(v + 16'd2));
        rd(4'd5, c);  check("R3 flag set", c, 32'h2);
        wr(4'd5, 16'h0002);
        idle(10);
        rd(4'd5, c);  check("R3 held high no recapture", c, 0);
        cap_in[1] = 1'b0;
        idle(6);
        rd(4'd5, c);  check("R3 falling edge ignored", c, 0);
    endtask

    task automatic t_compare;
        logic [15:0] v, f;
        wr(4'd2, 16'h0001);
        wr(4'd3, 16'h0003);
        wr(4'd5, 16'h001F);
        rd(4'd0, v); wr(4'd12, v + 16'd30);
        idle(8);
        check("R4 before match", pin_out[0], 0);
        idle(40);
        check("R4 high on match", pin_out[0], 1);
        rd(4'd5, f); check("R4 flag", f[0], 1);
        wr(4'd3, 16'h0002);
        rd(4'd0, v); wr(4'd12, v + 16'd30);
        idle(40);
        check("R4 low on match", pin_out[0], 0);
        wr(4'd3, 16'h0001);
        rd(4'd0, v); wr(4'd12, v + 16'd30);
        idle(40);
        check("R4 toggle on match", pin_out[0], 1);
        wr(4'd3, 16'h0000);
        check("R5 released pin shows port", pin_out[0], 0);
        wr(4'd5, 16'h001F);
        rd(4'd0, v); wr(4'd12, v + 16'd30);
        idle(40);
        rd(4'd5, f); check("R5 flag with mode 00", f[0], 1);
        check("R5 pin stays port", pin_out[0], 0);
    endtask

    task automatic t_force;
        logic [15:0] f;
        wr(4'd2, 16'h0005);
        wr(4'd3, 16'h0030);
        wr(4'd5, 16'h001F);
        wr(4'd6, 16'h0004);
        check("R6 forced high", pin_out[2], 1);
        rd(4'd5, f); check("R6 no flag", f, 0);
        rd(4'd6, f); check("R6 force reads zero", f, 0);
    endtask

    task automatic t_override;
        logic [15:0] v, f;
        wr(4'd2, 16'h000D);
        wr(4'd3, 16'h0033);
        wr(4'd7, 16'h0001);
        wr(4'd8, 16'h0000);
        wr(4'd3, 16'h0003);
        wr(4'd6, 16'h0001);
        check("R7 setup pin0 high", pin_out[0], 1);
        wr(4'd5, 16'h001F);
        rd(4'd0, v);
        wr(4'd12, v + 16'd40);
        wr(4'd15, v + 16'd40);
        idle(50);
        check("R7 override beats own compare", pin_out[0], 0);
        rd(4'd5, f); check("R7 both flags", f, 32'h9);
        wr(4'd8, 16'h0001);
        wr(4'd6, 16'h0008);
        check("R7 forced channel 3 override", pin_out[0], 1);
        wr(4'd7, 16'h0000);
    endtask

    task automatic t_restart;
        logic [15:0] v;
        wr(4'd1, 16'h0003);
        rd(4'd0, v);
        wr(4'd15, v + 16'd30);
        idle(50);
        rd(4'd0, v);
        check("R8 counter restarted", v < 16'd25, 1);
        wr(4'd1, 16'h0001);
    endtask

    task automatic t_port;
        logic [15:0] v;
        wr(4'd2, 16'h0003);
        wr(4'd3, 16'h000B);
        wr(4'd6, 16'h0002);
        wr(4'd9, 16'h0002);
        check("R9 owned pin ignores port", pin_out[1], 0);
        rd(4'd9, v); check("R9 port readback", v, 32'h2);
        wr(4'd3, 16'h0003);
        check("R9 latch appears on release", pin_out[1], 1);
        wr(4'd9, 16'h0000);
    endtask

    task automatic t_irq;
        logic [15:0] v, f;
        wr(4'd2, 16'h0001);
        wr(4'd4, 16'h001F);
        wr(4'd5, 16'h001F);
        check("R10 no irq when clear", {irq_ovf, irq_ch}, 0);
        rd(4'd0, v); wr(4'd12, v + 16'd20);
        cap_in[2] = 1'b1;
        idle(30);
        rd(4'd5, f); check("R10 flags", f, 32'h5);
        check("R10 irq mirrors flags", irq_ch, 4'h5);
        wr(4'd5, 16'h0001);
        rd(4'd5, f); check("R11 partial clear", f, 32'h4);
        check("R11 irq after clear", irq_ch, 4'h4);
        wr(4'd4, 16'h0000);
        check("R10 enable gates irq", irq_ch, 0);
        cap_in[2] = 1'b0;
        wr(4'd5, 16'h001F);
        wr(4'd4, 16'h0010);
    endtask

    task automatic t_overflow;
        logic [15:0] v, f;
        wr(4'd2, 16'h0000);
        wr(4'd5, 16'h001F);
        idle(3);
        rd(4'd5, f); check("R12 no overflow yet", f[4], 0);
        rd(4'd0, v);
        idle(65536 - int'(v) + 4);
        rd(4'd5, f); check("R12 overflow flag", f[4], 1);
        check("R12 overflow irq", irq_ovf, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_count();
        t_capture();
        t_compare();
        t_force();
        t_override();
        t_restart();
        t_port();
        t_irq();
        t_overflow();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule